// File: doc/BRIEF.md
# Masked Interrupt Line Router

This block sits between a cluster's interrupt sources and its cores. It takes a wide vector of level-sensitive request lines and drives a narrower vector of output lines. Each output has a private enable bit for every input. An output is high when at least one of the inputs it enables is high. The output is a registered OR of the masked inputs, so it follows its inputs one clock later.

Software reaches the block through a simple byte-addressed configuration port. Each output owns an aligned 1 KiB window, and each input's enable is one byte inside that window. The same port can read the enable bytes back. It can also read a latched snapshot of the raw input levels, packed into 64-bit status words. The defaults describe 157 inputs and 72 outputs. Both counts are parameters, and the bench uses a smaller build.

Top module: `irq_router`

## Requirements
- R1: After reset every output is low and every enable bit is zero; an enable byte read back after reset returns 0.
- R2: Output o at a clock edge equals the OR, over all inputs i, of (input i AND enable[o][i]) as sampled at the previous edge. This is one cycle of latency, and an output with no enabled input, or with all inputs low, stays low.
- R3: A write with byte address o*1024 + i, for o < N_OUT and i < N_IN, sets enable[o][i] to bit 0 of the write byte. Bits 7..1 of the byte are ignored.
- R4: A read of an enable byte address returns, one cycle after the read strobe, a 64-bit value with bit 0 equal to the enable and bits 63..1 zero.
- R5: A read of byte address 0x120 + 8*k, for k < ceil(N_IN/64), returns status word k one cycle after the strobe. Bit j of word k is the level of input 64*k + j, latched at the previous edge.
- R6: Status bits whose input index is N_IN or above read as zero. Reads of unmapped or unaligned addresses return zero.
- R7: Writes to an address whose input offset is N_IN or above, or whose output index is N_OUT or above, change no enable.
- R8: Outputs are independent: an enable set for one output has no effect on any other output.
- R9: When an output's last enabled active input drops, or its enable is cleared, the output falls one cycle after the edge that makes that change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_IN | Level interrupt requests |
| irq_out | output | N_OUT | Routed, registered interrupt outputs |
| cfg_addr | input | ADDR_W | Byte address for both reads and writes |
| cfg_wr | input | 1 | Write strobe |
| cfg_wdata | input | 8 | Write byte; only bit 0 is stored |
| cfg_rd | input | 1 | Read strobe |
| cfg_rdata | output | 64 | Read data, valid the cycle after cfg_rd |

## Verification
An output reflects its inputs and enables one clock edge after they are presented. The bench therefore drives stimulus just after a falling edge and compares irq_out at the next falling edge. It also confirms that the old value still holds in the half-cycle before the rising edge. An enable write lands at the rising edge that samples it, so a cleared enable drops its output one edge after that, and the bench checks both sides of that step. Read data appears one edge after the strobe. A status read is issued only after the input snapshot has been taken, which puts a pattern driven at cycle t on cfg_rdata after the edge t+2.

// File: rtl/ir_pkg.sv
package ir_pkg;
  localparam int STRIDE_LG = 10;     // each output owns a 1 KiB window
  localparam int STAT_BASE = 'h120;  // status words live in window 0
  localparam int WORD_W    = 64;

  // number of 64-bit words needed to hold n status bits
  function automatic int words_for(int n);
    return (n + WORD_W - 1) / WORD_W;
  endfunction

  // status word slot for a byte offset inside window 0, or -1 when none
  function automatic int stat_slot(int off, int n_words);
    int rel;
    rel = off - STAT_BASE;
    if (rel < 0 || rel >= n_words * 8 || (rel % 8) != 0) return -1;
    return rel / 8;
  endfunction

  // flat position of enable[o][i]
  function automatic int flat_idx(int o, int i, int n_in);
    return o * n_in + i;
  endfunction
endpackage

// File: rtl/ir_addr_dec.sv
module ir_addr_dec #(
  parameter int N_IN    = 157,
  parameter int N_OUT   = 72,
  parameter int N_WORDS = 3,
  parameter int ADDR_W  = 17,
  parameter int O_W     = 7,
  parameter int SW_W    = 2
) (
  input  logic [ADDR_W-1:0]            addr,
  output logic [O_W-1:0]               o_idx,
  output logic [ir_pkg::STRIDE_LG-1:0] i_idx,
  output logic                         en_hit,
  output logic                         st_hit,
  output logic [SW_W-1:0]              st_word
);
  int slot;

  always_comb begin
    o_idx   = addr[ADDR_W-1:ir_pkg::STRIDE_LG];
    i_idx   = addr[ir_pkg::STRIDE_LG-1:0];
    en_hit  = (int'(o_idx) < N_OUT) && (int'(i_idx) < N_IN);
    slot    = ir_pkg::stat_slot(int'(i_idx), N_WORDS);
    st_hit  = (o_idx == '0) && (slot >= 0);
    st_word = st_hit ? SW_W'(slot) : '0;
  end
endmodule

// File: rtl/ir_route_row.sv
module ir_route_row #(
  parameter int N_IN = 157
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_sel,
  input  logic [ir_pkg::STRIDE_LG-1:0] wr_idx,
  input  logic                         wr_val,
  input  logic [N_IN-1:0]              irq_in,
  output logic [N_IN-1:0]              en_vec,
  output logic                         irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_vec <= '0;
      irq_q  <= 1'b0;
    end else begin
      for (int b = 0; b < N_IN; b++) begin
        if (wr_sel && int'(wr_idx) == b) en_vec[b] <= wr_val;
      end
      irq_q <= |(irq_in & en_vec);
    end
  end
endmodule

// File: rtl/ir_stat_view.sv
module ir_stat_view #(
  parameter int N_IN    = 157,
  parameter int N_WORDS = 3,
  parameter int SW_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_IN-1:0]     irq_in,
  input  logic [SW_W-1:0]     word_sel,
  output logic [63:0]         word
);
  logic [N_IN-1:0]        snap_q;
  logic [N_WORDS*64-1:0]  padded;

  always_ff @(posedge clk) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= irq_in;
  end

  always_comb begin
    padded           = '0;
    padded[N_IN-1:0] = snap_q;
    word             = '0;
    for (int k = 0; k < N_WORDS; k++) begin
      if (int'(word_sel) == k) word = padded[k*64 +: 64];
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router #(
  parameter int N_IN  = 157,
  parameter int N_OUT = 72,
  localparam int ADDR_W = $clog2(N_OUT) + ir_pkg::STRIDE_LG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IN-1:0]   irq_in,
  output logic [N_OUT-1:0]  irq_out,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  input  logic              cfg_rd,
  output logic [63:0]       cfg_rdata
);
  localparam int N_WORDS = ir_pkg::words_for(N_IN);
  localparam int O_W     = $clog2(N_OUT);
  localparam int SW_W    = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

  logic [O_W-1:0]               o_idx;
  logic [ir_pkg::STRIDE_LG-1:0] i_idx;
  logic                         en_hit, st_hit, wr_go, en_bit;
  logic [SW_W-1:0]              st_word;
  logic [63:0]                  stat_word;
  logic [N_IN-1:0]              en_rows [N_OUT];
  logic [N_IN-1:0]              row_pick;
  logic [N_OUT*N_IN-1:0]        en_flat;
  logic                         wdata_unused;

  assign wdata_unused = ^cfg_wdata[7:1];
  assign wr_go        = cfg_wr && en_hit;

  ir_addr_dec #(
    .N_IN(N_IN), .N_OUT(N_OUT), .N_WORDS(N_WORDS),
    .ADDR_W(ADDR_W), .O_W(O_W), .SW_W(SW_W)
  ) u_dec (
    .addr(cfg_addr), .o_idx(o_idx), .i_idx(i_idx),
    .en_hit(en_hit), .st_hit(st_hit), .st_word(st_word)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_row
    ir_route_row #(.N_IN(N_IN)) u_row (
      .clk(clk), .rst_n(rst_n),
      .wr_sel(wr_go && int'(o_idx) == o),
      .wr_idx(i_idx), .wr_val(cfg_wdata[0]),
      .irq_in(irq_in), .en_vec(en_rows[o]), .irq_q(irq_out[o])
    );
    assign en_flat[o*N_IN +: N_IN] = en_rows[o];
  end

  ir_stat_view #(.N_IN(N_IN), .N_WORDS(N_WORDS), .SW_W(SW_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .word_sel(st_word), .word(stat_word)
  );

  // enable readback: pick the row, then the bit
  always_comb begin
    row_pick = '0;
    for (int o = 0; o < N_OUT; o++) begin
      if (int'(o_idx) == o) row_pick = en_rows[o];
    end
    en_bit = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (int'(i_idx) == i) en_bit = row_pick[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_rdata <= '0;
    end else if (cfg_rd) begin
      if (st_hit)      cfg_rdata <= stat_word;
      else if (en_hit) cfg_rdata <= {63'b0, en_bit};
      else             cfg_rdata <= '0;
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int N_IN  = 157,
  parameter int N_OUT = 72,
  localparam int O_W     = $clog2(N_OUT),
  localparam int N_WORDS = ir_pkg::words_for(N_IN),
  localparam int SW_W    = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
  localparam int FL_W    = $clog2(N_OUT * N_IN)
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [N_IN-1:0]              irq_in,
  input logic [N_OUT-1:0]             irq_out,
  input logic                         cfg_wr,
  input logic                         wr_bit,
  input logic                         cfg_rd,
  input logic [63:0]                  cfg_rdata,
  input logic                         en_hit,
  input logic                         st_hit,
  input logic [SW_W-1:0]              st_word,
  input logic [O_W-1:0]               o_idx,
  input logic [ir_pkg::STRIDE_LG-1:0] i_idx,
  input logic [N_OUT*N_IN-1:0]        en_flat
);
  localparam int REM = N_IN % 64;

  logic            was_rst;
  logic            pend;
  logic [FL_W-1:0] pidx;
  logic            pval;
  logic            last_rd;

  always_ff @(posedge clk) begin
    was_rst <= !rst_n;
    if (!rst_n) begin
      pend    <= 1'b0;
      pidx    <= '0;
      pval    <= 1'b0;
      last_rd <= 1'b0;
    end else begin
      pend    <= cfg_wr && en_hit;
      pidx    <= FL_W'(ir_pkg::flat_idx(int'(o_idx), int'(i_idx), N_IN));
      pval    <= wr_bit;
      last_rd <= cfg_rd && st_hit && (int'(st_word) == N_WORDS - 1);
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    was_rst |-> (irq_out == '0 && en_flat == '0));

  assert_idle_inputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_in == '0) |=> (irq_out == '0));

  assert_mask_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_flat == '0) |=> (irq_out == '0));

  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (en_flat[pidx] == pval));

  assert_enable_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && en_hit) |=> (cfg_rdata[63:1] == '0));

  assert_oob_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !en_hit) |=> $stable(en_flat));

  if (REM != 0) begin : g_pad
    assert_pad_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      last_rd |-> ((cfg_rdata >> REM) == '0));
  end
endmodule

bind irq_router irq_router_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_out(irq_out),
  .cfg_wr(cfg_wr), .wr_bit(cfg_wdata[0]), .cfg_rd(cfg_rd),
  .cfg_rdata(cfg_rdata), .en_hit(en_hit), .st_hit(st_hit),
  .st_word(st_word), .o_idx(o_idx), .i_idx(i_idx), .en_flat(en_flat)
);

// File: tb/sim_irq_router.sv
module sim_irq_router;
  localparam int NI = 70;
  localparam int NO = 3;
  localparam int AW = $clog2(NO) + 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] irq_in = '0;
  logic [NO-1:0] irq_out;
  logic [AW-1:0] cfg_addr = '0;
  logic          cfg_wr = 1'b0;
  logic [7:0]    cfg_wdata = '0;
  logic          cfg_rd = 1'b0;
  logic [63:0]   cfg_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  irq_router #(.N_IN(NI), .N_OUT(NO)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_out(irq_out),
    .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata)
  );

  // enables used by the table: out0 <- in0,in5 ; out1 <- in69 ; out2 <- in33
  localparam logic [NI+NO-1:0] TBL [8] = '{
    {3'b000, 70'd0},
    {3'b001, 70'd1},
    {3'b001, 70'd1 << 5},
    {3'b010, 70'd1 << 69},
    {3'b100, 70'd1 << 33},
    {3'b000, (70'd1 << 1) | (70'd1 << 68)},
    {3'b111, {70{1'b1}}},
    {3'b101, (70'd1 << 5) | (70'd1 << 33)}
  };

  function automatic logic [AW-1:0] adr(int o, int i);
    return AW'(o * 1024 + i);
  endfunction

  function automatic logic [63:0] want_word(logic [NI-1:0] p, int k);
    logic [63:0] w;
    w = '0;
    for (int j = 0; j < 64; j++) begin
      if (64 * k + j < NI) w[j] = p[64 * k + j];
    end
    return w;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(int o, int i, logic [7:0] d);
    @(negedge clk);
    cfg_addr = adr(o, i); cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_addr(logic [AW-1:0] a, output logic [63:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_rd = 1'b1;
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    check("R1 outputs", 64'(irq_out), 64'h0);
    rd_addr(adr(1, 69), d);
    check("R1 enable readback", d, 64'h0);

    // R3: program enables; upper bits of the byte ignored
    wr(0, 0, 8'h01);
    wr(0, 5, 8'hFF);
    wr(1, 69, 8'h01);
    wr(2, 33, 8'h03);
    wr(1, 2, 8'hFE);
    rd_addr(adr(0, 5), d);
    check("R3/R4 enable set by bit0", d, 64'h1);
    rd_addr(adr(1, 2), d);
    check("R3 bit0 clear keeps enable off", d, 64'h0);
    rd_addr(adr(2, 33), d);
    check("R4 readback upper bits zero", d, 64'h1);

    // R7: writes outside the mapped ranges
    wr(0, NI, 8'h01);
    wr(3, 1, 8'h01);
    rd_addr(adr(3, 1), d);
    check("R7 out-of-range output", d, 64'h0);
    rd_addr(adr(0, 1), d);
    check("R7 neighbour untouched", d, 64'h0);

    // R2/R8/R5/R6: table walk
    for (int r = 0; r < 8; r++) begin
      logic [NI-1:0] pat;
      logic [NO-1:0] exp_o;
      pat   = TBL[r][NI-1:0];
      exp_o = TBL[r][NI+NO-1:NI];
      @(negedge clk);
      irq_in = pat;
      @(negedge clk);
      check($sformatf("R2/R8 row %0d outputs", r), 64'(irq_out), 64'(exp_o));
      rd_addr(12'h120, d);
      check($sformatf("R5 row %0d word0", r), d, want_word(pat, 0));
      rd_addr(12'h128, d);
      check($sformatf("R5/R6 row %0d word1", r), d, want_word(pat, 1));
    end

    // R6: unmapped and unaligned reads
    rd_addr(12'h121, d);
    check("R6 unaligned read", d, 64'h0);
    rd_addr(12'h130, d);
    check("R6 word past count", d, 64'h0);

    // R2: one-cycle latency, sampled before and after the edge
    @(negedge clk);
    irq_in = 70'd1 << 69;
    #1 check("R2 before edge", 64'(irq_out), 64'b101);
    @(negedge clk);
    check("R2 after edge", 64'(irq_out), 64'b010);

    // R9: clear enable with input held high
    @(negedge clk);
    irq_in = {NI{1'b1}};
    @(negedge clk);
    check("R9 all on", 64'(irq_out), 64'b111);
    wr(2, 33, 8'h00);
    check("R9 still high one edge after clear", 64'(irq_out[2]), 64'h1);
    @(negedge clk);
    check("R9 falls after clear", 64'(irq_out), 64'b011);
    irq_in = '0;
    @(negedge clk);
    check("R9 falls when inputs drop", 64'(irq_out), 64'b000);

    // R1: reset clears enables again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    irq_in = {NI{1'b1}};
    @(negedge clk);
    check("R1 outputs after second reset", 64'(irq_out), 64'h0);
    rd_addr(adr(0, 0), d);
    check("R1 enable cleared by reset", d, 64'h0);

    finish_run();
  end
endmodule